// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block holds one 32-bit control and status word for a group of seven DMA channels and turns channel completions into a single level interrupt for the processor. Each channel reports the end of a transfer with a one-cycle pulse. The block records a pending flag for that channel and decides whether the processor must be interrupted. It makes that decision only when a completion arrives. A master enable and a per-channel enable both take part in the decision.

Software sees the word through a register port with byte-lane write strobes. The enable bits and the low general-purpose bits are plain read/write bits. A pending flag is cleared by writing a one to it. The top bit is a master flag that only the hardware sets. It mirrors the interrupt line. Once software has cleared every pending flag, the flag drops and the line is released. The read path is the register value itself, so reading has no side effects.

Bit layout: [31] master flag, [30:24] pending flags for channels 6..0, [23] master enable, [22:16] channel enables for channels 6..0, [15:0] general read/write bits. The per-channel filtering depends on the pending field sitting exactly eight bits above the enable field.

Top module: `dmairq_ctrl`

## Requirements
- R1: During and after reset the register reads 0x00000000 and `irq` is low.
- R2: A pulse on `done_i[n]` sets bit 24+n, provided channel enable bit 16+n is 1. If that enable bit is 0, the flag is dropped in the same update and bit 24+n stays 0.
- R3: On a completion, the master flag (bit 31) is set if the master enable (bit 23) is 1 and at least one pending bit 24+k has its enable bit 16+k set. When the master enable is 0, bit 31 is not set and the pending flags are still recorded.
- R4: Every completion update filters the register. Each pending bit 24+k is cleared when enable bit 16+k is 0, and bit 31 is cleared when bit 23 is 0.
- R5: A write with `wr_en` high loads bits 23..0 from `wr_data`. It clears each bit in 30..24 where `wr_data` has a 1 and leaves the others. Bit 31 ignores the written data.
- R6: A write changes only the bytes whose `wr_strb` bit is 1: strobe bit i covers bits 8i+7..8i. All other bytes keep their value. Without a write, bits 23..0 never change.
- R7: After a write, if bit 31 is set and bits 30..24 are all zero, bit 31 is cleared and `irq` goes low. While any pending flag remains, bit 31 stays set.
- R8: `irq` equals bit 31 of the register at all times.
- R9: `rd_data` shows the whole 32-bit register, and observing it changes nothing.
- R10: When a write and a completion fall in the same cycle, the write, including its R7 check, is applied first. The completion is then set and evaluated, so the new event is kept.
- R11: Evaluation happens only on completions. Setting the master enable or a channel enable by a write never sets bit 31, even if enabled flags are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 7 | Per-channel completion pulses, bit n for channel n |
| wr_en | input | 1 | Register write request |
| wr_strb | input | 4 | Byte-lane write strobes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| irq | output | 1 | Level interrupt to the processor |

## Verification
All effects of a write or a completion sampled at one rising edge appear on `rd_data` and `irq` right after that edge, a single cycle of latency. Nothing is combinational from input to output. The bench drives each stimulus at a falling edge, holds it across exactly one rising edge, removes it, and compares both outputs at the next falling edge. Idle cycles between vectors therefore cannot mask a result. The idle-hold check confirms that waiting changes nothing.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    localparam int NUM_CH    = 7;
    localparam int REG_W     = 32;
    localparam int LANES     = REG_W / 8;
    localparam int PEND_LSB  = 24;
    localparam int EN_LSB    = 16;
    localparam int MEN_BIT   = PEND_LSB - 1;
    localparam int MFLAG_BIT = PEND_LSB + NUM_CH;
    localparam int GAP       = PEND_LSB - EN_LSB;

    localparam logic [REG_W-1:0] LOW_MASK  = (REG_W'(1) << PEND_LSB) - REG_W'(1);
    localparam logic [REG_W-1:0] PEND_MASK = ((REG_W'(1) << NUM_CH) - REG_W'(1)) << PEND_LSB;
    localparam logic [REG_W-1:0] FLAG_MASK = REG_W'(1) << MFLAG_BIT;

    typedef struct packed {
        logic [REG_W-1:0] word;
    } state_t;
endpackage

// File: rtl/dmairq_lane_expand.sv
module dmairq_lane_expand #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0]   strb,
    output logic [LANES*8-1:0] bit_mask
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bit_mask[i*8 +: 8] = {8{strb[i]}};
    end
endmodule

// File: rtl/dmairq_cpu_merge.sv
module dmairq_cpu_merge
    import dmairq_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic             wr_en,
    input  logic [REG_W-1:0] bit_mask,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] merged
);
    logic [REG_W-1:0] after_wr;

    always_comb begin
        if (wr_en) begin
            after_wr = (cur & (FLAG_MASK | ~bit_mask))
                     | (cur & ~wr_data & PEND_MASK & bit_mask)
                     | (wr_data & LOW_MASK & bit_mask);
            if (after_wr[MFLAG_BIT] && ((after_wr & PEND_MASK) == '0)) begin
                after_wr[MFLAG_BIT] = 1'b0;
            end
        end else begin
            after_wr = cur;
        end
        merged = after_wr;
    end
endmodule

// File: rtl/dmairq_event_eval.sv
module dmairq_event_eval
    import dmairq_pkg::*;
(
    input  logic [REG_W-1:0]  cur,
    input  logic [NUM_CH-1:0] done,
    output logic [REG_W-1:0]  next
);
    logic [REG_W-1:0]  with_set;
    logic [NUM_CH-1:0] live;

    always_comb begin
        with_set = cur | ({{(REG_W-NUM_CH){1'b0}}, done} << PEND_LSB);
        live     = with_set[PEND_LSB +: NUM_CH] & with_set[EN_LSB +: NUM_CH];
        if (done != '0) begin
            if (with_set[MEN_BIT] && (live != '0)) begin
                with_set[MFLAG_BIT] = 1'b1;
            end
            next = with_set & (LOW_MASK | (with_set << GAP));
        end else begin
            next = cur;
        end
    end
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
    import dmairq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    done_i,
    input  logic                 wr_en,
    input  logic [LANES-1:0]     wr_strb,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic                 irq
);
    state_t st_d, st_q;
    logic [REG_W-1:0] lane_bits;
    logic [REG_W-1:0] post_wr;
    logic [REG_W-1:0] post_evt;

    dmairq_lane_expand #(.LANES(LANES)) u_lanes (
        .strb     (wr_strb),
        .bit_mask (lane_bits)
    );

    dmairq_cpu_merge u_merge (
        .cur      (st_q.word),
        .wr_en    (wr_en),
        .bit_mask (lane_bits),
        .wr_data  (wr_data),
        .merged   (post_wr)
    );

    dmairq_event_eval u_eval (
        .cur  (post_wr),
        .done (done_i),
        .next (post_evt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.word = post_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.word;
    assign irq     = st_q.word[MFLAG_BIT];
endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk
    import dmairq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] done_i,
    input logic              wr_en,
    input logic [LANES-1:0]  wr_strb,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> (rd_data == '0 && !irq)); // R1

    AST_PEND_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i == '0) |=> ((rd_data[PEND_LSB +: NUM_CH] & ~$past(rd_data[PEND_LSB +: NUM_CH])) == '0)); // R2

    AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i == '0) |=> !$rose(rd_data[MFLAG_BIT])); // R11

    AST_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i != '0) |=> ((rd_data[PEND_LSB +: NUM_CH] & ~rd_data[EN_LSB +: NUM_CH]) == '0)); // R4

    AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[PEND_LSB-1:0])); // R6

    AST_LANE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_strb[0]) |=> $stable(rd_data[7:0])); // R6

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb[LANES-1] && done_i == '0 &&
         (rd_data[PEND_LSB +: NUM_CH] & ~wr_data[PEND_LSB +: NUM_CH]) == '0) |=> !irq); // R7

    AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        irq == rd_data[MFLAG_BIT]); // R8
endmodule

bind dmairq_ctrl dmairq_ctrl_chk u_chk (.*);

// File: tb/sim_dmairq_ctrl.sv
module sim_dmairq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  done_i = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dmairq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .wr_en(wr_en),
        .wr_strb(wr_strb), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // {done, wr_en, strb, data, expected word, expected irq}
    localparam int NV = 17;
    localparam logic [76:0] VECS [NV] = '{
        {7'h00, 1'b1, 4'b0111, 32'h0085_1234, 32'h0085_1234, 1'b0}, // R5 load low bytes
        {7'h01, 1'b0, 4'b0000, 32'h0,         32'h8185_1234, 1'b1}, // R3 fire
        {7'h02, 1'b0, 4'b0000, 32'h0,         32'h8185_1234, 1'b1}, // R2 disabled channel dropped
        {7'h00, 1'b1, 4'b1000, 32'h8200_0000, 32'h8185_1234, 1'b1}, // R5 flag not writable, R7 hold
        {7'h00, 1'b1, 4'b1000, 32'h0100_0000, 32'h0085_1234, 1'b0}, // R7 release
        {7'h00, 1'b1, 4'b0001, 32'hFFFF_FFAB, 32'h0085_12AB, 1'b0}, // R6 single lane
        {7'h04, 1'b1, 4'b0100, 32'h0004_0000, 32'h0404_12AB, 1'b0}, // R10 write then set, R3 master off
        {7'h00, 1'b1, 4'b0100, 32'h0084_0000, 32'h0484_12AB, 1'b0}, // R11 enable write no fire
        {7'h08, 1'b0, 4'b0000, 32'h0,         32'h8484_12AB, 1'b1}, // R4 filter and fire
        {7'h00, 1'b1, 4'b0100, 32'h0001_0000, 32'h8401_12AB, 1'b1}, // R7 flag held
        {7'h01, 1'b0, 4'b0000, 32'h0,         32'h0101_12AB, 1'b0}, // R4 flag cleared by filter
        {7'h00, 1'b1, 4'b1111, 32'h0100_0000, 32'h0000_0000, 1'b0}, // R5 full write
        {7'h00, 1'b1, 4'b1111, 32'h00FF_0000, 32'h00FF_0000, 1'b0}, // R5 all enables
        {7'h7F, 1'b0, 4'b0000, 32'h0,         32'hFFFF_0000, 1'b1}, // R2 all channels
        {7'h00, 1'b1, 4'b1000, 32'h3F00_0000, 32'hC0FF_0000, 1'b1}, // R7 partial clear
        {7'h40, 1'b1, 4'b1000, 32'h4000_0000, 32'hC0FF_0000, 1'b1}, // R10 clear and set same cycle
        {7'h00, 1'b1, 4'b1000, 32'h7F00_0000, 32'h00FF_0000, 1'b0}  // R7 release
    };

    task automatic check_word(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%08h expected %08h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [6:0] d, input logic we, input logic [3:0] s, input logic [31:0] w);
        @(negedge clk);
        done_i = d; wr_en = we; wr_strb = s; wr_data = w;
        @(posedge clk);
        #1;
        done_i = '0; wr_en = 1'b0; wr_strb = '0; wr_data = '0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_word("R1", rd_data, 32'h0);
        check_bit("R1", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_word("R1", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][76:70], VECS[i][69], VECS[i][68:65], VECS[i][64:33]);
            check_word($sformatf("vector %0d", i), rd_data, VECS[i][32:1]);
            check_bit($sformatf("R8 vector %0d", i), irq, VECS[i][0]);
        end

        // R9: idle cycles leave the observed value unchanged
        repeat (5) @(negedge clk);
        check_word("R9", rd_data, 32'h00FF_0000);

        // R2/R3 with master enable set but a disabled channel: no flag, no irq
        apply(7'h00, 1'b1, 4'b0100, 32'h0080_0000);
        apply(7'h10, 1'b0, 4'b0000, 32'h0);
        check_word("R2 disabled ch4", rd_data, 32'h0080_0000);
        check_bit("R3 disabled ch4", irq, 1'b0);

        // R6: write with no strobes changes nothing
        apply(7'h00, 1'b1, 4'b0000, 32'hFFFF_FFFF);
        check_word("R6 no strobe", rd_data, 32'h0080_0000);

        // R1: reset in the middle of activity
        apply(7'h00, 1'b1, 4'b0100, 32'h0081_0000);
        apply(7'h01, 1'b0, 4'b0000, 32'h0);
        check_bit("R3 before reset", irq, 1'b1);
        rst_n = 1'b0;
        #1;
        check_word("R1 mid reset", rd_data, 32'h0);
        check_bit("R1 mid reset", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_word("R1 after reset", rd_data, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule